// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block finds the Ethernet PHYs attached to a shared management bus. One pulse on `start` begins a sweep over all 32 management addresses in ascending order. At each address it asks an external management-frame engine for the basic status register through a one-at-a-time request/response port. A status word that is neither all zeros nor all ones means a PHY answers at that address. For each PHY found, the scanner appends the address to a result table and then reads that PHY's advertisement register. The sweep ends early once the table is full.

At the end of the sweep the block publishes the number of PHYs found and a primary address. The primary address is the first table entry, or 1 when nothing answered. It also publishes the advertisement word of the last PHY found and a flag that tells later management traffic whether it must send a preamble. That flag is set when any PHY found lacks the preamble-suppression capability. An error flag marks a sweep that found nothing. A one-cycle `done` pulse marks the end of the sweep, and every result then holds until the next start.

The controller has seven states:

| State | Role and transitions |
|---|---|
| S_IDLE | Waits. START_SCAN: `start` goes to S_ISSUE_STAT. |
| S_ISSUE_STAT | Issues the status read, then ISSUED_STAT goes to S_WAIT_STAT. |
| S_WAIT_STAT | Waits for the response. On it, FOUND goes to S_ISSUE_ADV and ABSENT goes to S_STEP. |
| S_ISSUE_ADV | Issues the advertisement read, then ISSUED_ADV goes to S_WAIT_ADV. |
| S_WAIT_ADV | Waits for the response. On it, CAPTURED goes to S_STEP. |
| S_STEP | ADVANCE goes back to S_ISSUE_STAT with the next address. WRAP_UP goes to S_FINISH at address 31 or when the table is full. |
| S_FINISH | Pulses `done`, then RETURN goes to S_IDLE. |

Top module: `phy_discovery_scanner`

## Requirements
- R1: After `start`, the block issues exactly one status read (`req_reg` = 1) for each address, in ascending order from 0. It stops after address 31, or earlier once the table holds MAX_PHY entries. In that case no further address is read.
- R2: A status response counts as a PHY present only when its value is neither 16'h0000 nor 16'hFFFF. Any other value, including 16'h0040 and 16'hFFBF, counts as present.
- R3: Each present address is written into the next free table slot, and `phy_count` is incremented. Slot i occupies `phy_table[5*i +: 5]`. Slots not filled in the current sweep read as 0. `phy_count` never exceeds MAX_PHY.
- R4: Directly after a present status, the block issues an advertisement read (`req_reg` = 4) to the same address. `adv_value` holds the response of the last such read in the sweep. It is cleared to 0 at start.
- R5: Every request issued has `req_preamble` high.
- R6: At the end of the sweep, `preamble_req` is 1 if any present PHY returned status bit 6 = 0, and 0 otherwise. It keeps its previous value while the sweep runs.
- R7: `primary_phy` is 1 after reset. At the end of a sweep it is `phy_table` slot 0 if any PHY was found, and 1 otherwise.
- R8: `no_phy_err` is 1 at the end of a sweep that found no PHY, and 0 otherwise. It is cleared at start and is 0 after reset.
- R9: `req_valid` is a one-cycle pulse. A new request is never issued before `rsp_done` has answered the previous one.
- R10: `done` is high for exactly one cycle at the end of a sweep. `start` is honoured only in S_IDLE, so a `start` during a sweep or in the `done` cycle is ignored. Results hold unchanged, and no request is issued, until the next honoured `start`.
- R11: After reset, `phy_count`, `adv_value`, `preamble_req`, `done` and `req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (pulse) |
| req_valid | output | 1 | One-cycle request to the management-frame engine |
| req_phy | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| req_preamble | output | 1 | Request a preamble before the frame |
| rsp_done | input | 1 | One-cycle response strobe |
| rsp_data | input | 16 | Read data, valid with `rsp_done` |
| phy_table | output | 5*MAX_PHY | Found addresses, slot i at bits [5*i +: 5] |
| phy_count | output | $clog2(MAX_PHY+1) | Number of PHYs found |
| primary_phy | output | 5 | Primary PHY address |
| adv_value | output | 16 | Advertisement word of the last PHY found |
| preamble_req | output | 1 | Later frames need a preamble |
| no_phy_err | output | 1 | The sweep found no PHY |
| done | output | 1 | End-of-sweep pulse |

## Verification
The sweep can end for two reasons, and both can hold in the same S_STEP cycle. One is that the table becomes full; the other is that address 31 has been reached. The bench provokes this with a fourth PHY placed at address 31. It checks that exactly 32 status reads and 4 advertisement reads occur, that the full table and the advertisement word of address 31 are reported, and that `done` pulses once. It also raises `start` exactly in the `done` cycle, where the finish and a new start coincide. It then checks that no request follows and that the results stay as they were.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
    localparam int          ADDR_W       = 5;
    localparam int          REG_W        = 5;
    localparam int          DATA_W       = 16;
    localparam int          SUPPR_BIT    = 6;
    localparam logic [4:0]  REG_BMSTAT   = 5'd1;
    localparam logic [4:0]  REG_ADVERT   = 5'd4;
    localparam logic [4:0]  LAST_ADDR    = 5'd31;
    localparam logic [4:0]  PRIMARY_DFLT = 5'd1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE_STAT,
        S_WAIT_STAT,
        S_ISSUE_ADV,
        S_WAIT_ADV,
        S_STEP,
        S_FINISH
    } scan_state_t;
endpackage

// File: rtl/phy_presence_judge.sv
module phy_presence_judge
    import phy_scan_pkg::*;
(
    input  logic [DATA_W-1:0] status,
    output logic              present,
    output logic              needs_pre
);
    always_comb begin
        present   = (status != '0) && (status != '1);
        needs_pre = present && !status[SUPPR_BIT];
    end
endmodule

// File: rtl/phy_addr_table.sv
module phy_addr_table
    import phy_scan_pkg::*;
#(
    parameter int MAX_PHY = 4,
    localparam int CNT_W  = $clog2(MAX_PHY + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    output logic [MAX_PHY*ADDR_W-1:0] table_flat,
    output logic [CNT_W-1:0]          count,
    output logic                      full,
    output logic [ADDR_W-1:0]         first_entry
);
    logic [ADDR_W-1:0] slot_q [MAX_PHY];

    for (genvar i = 0; i < MAX_PHY; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (clear)
                slot_q[i] <= '0;
            else if (wr_en && (count == CNT_W'(i)))
                slot_q[i] <= wr_addr;
        end
        assign table_flat[i*ADDR_W +: ADDR_W] = slot_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (wr_en && !full)
            count <= count + 1'b1;
    end

    assign full        = (count == CNT_W'(MAX_PHY));
    assign first_entry = slot_q[0];
endmodule

// File: rtl/phy_scan_ctrl.sv
module phy_scan_ctrl
    import phy_scan_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rsp_done,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              present,
    input  logic              needs_pre,
    input  logic [CNT_W-1:0]  tbl_count,
    input  logic              tbl_full,
    input  logic [ADDR_W-1:0] tbl_first,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_phy,
    output logic [REG_W-1:0]  req_reg,
    output logic              req_preamble,
    output logic              tbl_clear,
    output logic              tbl_wr,
    output logic [DATA_W-1:0] adv_value,
    output logic              preamble_req,
    output logic              no_phy_err,
    output logic [ADDR_W-1:0] primary_phy,
    output logic              done
);
    scan_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              pre_acc_q;
    logic              last_step;

    assign last_step = (addr_q == LAST_ADDR) || tbl_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start) state_d = S_ISSUE_STAT;
            S_ISSUE_STAT: state_d = S_WAIT_STAT;
            S_WAIT_STAT:  if (rsp_done) state_d = present ? S_ISSUE_ADV : S_STEP;
            S_ISSUE_ADV:  state_d = S_WAIT_ADV;
            S_WAIT_ADV:   if (rsp_done) state_d = S_STEP;
            S_STEP:       state_d = last_step ? S_FINISH : S_ISSUE_STAT;
            S_FINISH:     state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid    = 1'b0;
        req_reg      = REG_BMSTAT;
        req_preamble = 1'b0;
        tbl_clear    = 1'b0;
        tbl_wr       = 1'b0;
        done         = 1'b0;
        unique case (state_q)
            S_IDLE:       tbl_clear = start;
            S_ISSUE_STAT: begin
                req_valid    = 1'b1;
                req_preamble = 1'b1;
            end
            S_WAIT_STAT:  tbl_wr = rsp_done && present;
            S_ISSUE_ADV:  begin
                req_valid    = 1'b1;
                req_reg      = REG_ADVERT;
                req_preamble = 1'b1;
            end
            S_FINISH:     done = 1'b1;
            default:      ;
        endcase
    end
    assign req_phy = addr_q;

    // sweep datapath and published results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q       <= '0;
            pre_acc_q    <= 1'b0;
            adv_value    <= '0;
            preamble_req <= 1'b0;
            no_phy_err   <= 1'b0;
            primary_phy  <= PRIMARY_DFLT;
        end else begin
            if (state_q == S_IDLE && start) begin
                addr_q     <= '0;
                pre_acc_q  <= 1'b0;
                adv_value  <= '0;
                no_phy_err <= 1'b0;
            end
            if (tbl_wr && needs_pre)
                pre_acc_q <= 1'b1;
            if (state_q == S_WAIT_ADV && rsp_done)
                adv_value <= rsp_data;
            if (state_q == S_STEP) begin
                if (last_step) begin
                    preamble_req <= pre_acc_q;
                    no_phy_err   <= (tbl_count == '0);
                    primary_phy  <= (tbl_count == '0) ? PRIMARY_DFLT : tbl_first;
                end else begin
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/phy_discovery_scanner.sv
module phy_discovery_scanner
    import phy_scan_pkg::*;
#(
    parameter int MAX_PHY = 4,
    localparam int CNT_W  = $clog2(MAX_PHY + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output logic                      req_valid,
    output logic [4:0]                req_phy,
    output logic [4:0]                req_reg,
    output logic                      req_preamble,
    input  logic                      rsp_done,
    input  logic [15:0]               rsp_data,
    output logic [MAX_PHY*5-1:0]      phy_table,
    output logic [CNT_W-1:0]          phy_count,
    output logic [4:0]                primary_phy,
    output logic [15:0]               adv_value,
    output logic                      preamble_req,
    output logic                      no_phy_err,
    output logic                      done
);
    logic              present, needs_pre;
    logic              tbl_clear, tbl_wr, tbl_full;
    logic [ADDR_W-1:0] tbl_first;

    phy_presence_judge u_judge (
        .status    (rsp_data),
        .present   (present),
        .needs_pre (needs_pre)
    );

    phy_addr_table #(.MAX_PHY(MAX_PHY)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (tbl_clear),
        .wr_en       (tbl_wr),
        .wr_addr     (req_phy),
        .table_flat  (phy_table),
        .count       (phy_count),
        .full        (tbl_full),
        .first_entry (tbl_first)
    );

    phy_scan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .rsp_done     (rsp_done),
        .rsp_data     (rsp_data),
        .present      (present),
        .needs_pre    (needs_pre),
        .tbl_count    (phy_count),
        .tbl_full     (tbl_full),
        .tbl_first    (tbl_first),
        .req_valid    (req_valid),
        .req_phy      (req_phy),
        .req_reg      (req_reg),
        .req_preamble (req_preamble),
        .tbl_clear    (tbl_clear),
        .tbl_wr       (tbl_wr),
        .adv_value    (adv_value),
        .preamble_req (preamble_req),
        .no_phy_err   (no_phy_err),
        .primary_phy  (primary_phy),
        .done         (done)
    );
endmodule

// File: rtl/phy_scan_checker.sv
module phy_scan_checker #(
    parameter int MAX_PHY = 4,
    localparam int CNT_W  = $clog2(MAX_PHY + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 req_valid,
    input logic                 rsp_done,
    input logic [MAX_PHY*5-1:0] phy_table,
    input logic [CNT_W-1:0]     phy_count,
    input logic [4:0]           primary_phy,
    input logic [15:0]          adv_value,
    input logic                 preamble_req,
    input logic                 no_phy_err,
    input logic                 done
);
    logic outstanding;
    logic settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         outstanding <= 1'b0;
        else if (req_valid) outstanding <= 1'b1;
        else if (rsp_done)  outstanding <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     settled <= 1'b0;
        else if (done)  settled <= 1'b1;
        else if (start) settled <= 1'b0;
    end

    p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !outstanding);

    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phy_count <= CNT_W'(MAX_PHY));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_noerr_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (no_phy_err == (phy_count == '0)));

    p_primary_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && phy_count != '0) |-> (primary_phy == phy_table[4:0]));

    p_primary_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && phy_count == '0) |-> (primary_phy == 5'd1));

    p_hold_results_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !start) |=> ($stable(phy_count) && $stable(phy_table) &&
                                 $stable(adv_value) && $stable(preamble_req) &&
                                 $stable(primary_phy) && $stable(no_phy_err)));

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !start) |-> !req_valid);
endmodule

bind phy_discovery_scanner phy_scan_checker #(.MAX_PHY(MAX_PHY)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .req_valid    (req_valid),
    .rsp_done     (rsp_done),
    .phy_table    (phy_table),
    .phy_count    (phy_count),
    .primary_phy  (primary_phy),
    .adv_value    (adv_value),
    .preamble_req (preamble_req),
    .no_phy_err   (no_phy_err),
    .done         (done)
);

// File: tb/tb_phy_discovery_scanner.sv
module tb_phy_discovery_scanner;
    localparam int MAX_PHY = 4;
    localparam int CNT_W   = $clog2(MAX_PHY + 1);
    localparam int LAT     = 3;
    localparam int NVEC    = 6;
    localparam int WD_LIMIT = 150000;

    // sweep vectors: presence mask, suppression-capable mask, expected count/primary/preamble/error
    localparam logic [31:0] V_MASK [NVEC] = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0088,
                                             32'h4010_1224, 32'h8000_0000, 32'h8000_000E};
    localparam logic [31:0] V_SUPP [NVEC] = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0008,
                                             32'h4000_1224, 32'h0000_0000, 32'h8000_000E};
    localparam int          V_CNT  [NVEC] = '{0, 1, 3, 4, 1, 4};
    localparam int          V_PRIM [NVEC] = '{1, 0, 3, 2, 31, 1};
    localparam bit          V_PRE  [NVEC] = '{0, 0, 1, 0, 1, 0};
    localparam bit          V_ERR  [NVEC] = '{1, 0, 0, 0, 0, 0};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 req_valid, req_preamble;
    logic [4:0]           req_phy, req_reg;
    logic                 rsp_done = 1'b0;
    logic [15:0]          rsp_data = '0;
    logic [MAX_PHY*5-1:0] phy_table;
    logic [CNT_W-1:0]     phy_count;
    logic [4:0]           primary_phy;
    logic [15:0]          adv_value;
    logic                 preamble_req, no_phy_err, done;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [31:0] cur_mask = '0;
    logic [31:0] cur_supp = '0;

    always #5 clk = ~clk;

    phy_discovery_scanner #(.MAX_PHY(MAX_PHY)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_phy(req_phy), .req_reg(req_reg),
        .req_preamble(req_preamble), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .phy_table(phy_table), .phy_count(phy_count), .primary_phy(primary_phy),
        .adv_value(adv_value), .preamble_req(preamble_req),
        .no_phy_err(no_phy_err), .done(done)
    );

    function automatic logic [15:0] status_of(input logic [4:0] a);
        if (cur_mask[a])
            return cur_supp[a] ? (a[1] ? 16'h0040 : 16'h7869) : (a[1] ? 16'hFFBF : 16'h7829);
        return a[0] ? 16'hFFFF : 16'h0000;
    endfunction

    function automatic logic [15:0] adv_of(input logic [4:0] a);
        return 16'h05E0 | {11'd0, a};
    endfunction

    // PHY side model and request monitor
    int          pend = 0;
    logic [4:0]  p_reg, p_phy, last_phy;
    int          exp_addr = 0;
    bit          adv_expect = 0;
    int          n_req = 0, order_err = 0, pre_err = 0, overlap_err = 0;

    always @(negedge clk) begin
        rsp_done <= 1'b0;
        if (done) begin
            exp_addr   = 0;
            adv_expect = 0;
        end
        if (req_valid) begin
            n_req++;
            if (!req_preamble) pre_err++;
            if (pend != 0) overlap_err++;
            if (req_reg == 5'd1) begin
                if (adv_expect || int'(req_phy) != exp_addr) order_err++;
                adv_expect = cur_mask[req_phy];
                last_phy   = req_phy;
                exp_addr++;
            end else if (req_reg == 5'd4) begin
                if (!adv_expect || req_phy != last_phy) order_err++;
                adv_expect = 0;
            end else begin
                order_err++;
            end
            pend  = LAT;
            p_reg = req_reg;
            p_phy = req_phy;
        end else if (pend != 0) begin
            pend--;
            if (pend == 0) begin
                rsp_done <= 1'b1;
                rsp_data <= (p_reg == 5'd1) ? status_of(p_phy) : adv_of(p_phy);
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // expected values computed from the requirements
    int                   e_cnt, e_req;
    bit                   e_pre;
    logic [15:0]          e_adv;
    logic [MAX_PHY*5-1:0] e_tbl;

    task automatic expect_from_masks();
        e_cnt = 0; e_req = 0; e_pre = 0; e_adv = '0; e_tbl = '0;
        for (int a = 0; a < 32; a++) begin
            e_req++;
            if (cur_mask[a]) begin
                e_tbl[e_cnt*5 +: 5] = 5'(a);
                e_cnt++;
                e_req++;
                e_adv = adv_of(5'(a));
                if (!cur_supp[a]) e_pre = 1;
                if (e_cnt == MAX_PHY) break;
            end
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic run_vec(input int v, input int extra_start_at, input bit start_in_done);
        int r0, o0, p0, x0;
        bit seen;
        cur_mask = V_MASK[v];
        cur_supp = V_SUPP[v];
        expect_from_masks();
        r0 = n_req; o0 = order_err; p0 = pre_err; x0 = overlap_err;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra_start_at > 0) begin
            repeat (extra_start_at) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait_done(seen);
        check(seen, $sformatf("R10 done seen v%0d", v), 32'(seen), 1);
        check(int'(phy_count) == V_CNT[v] && int'(phy_count) == e_cnt,
              $sformatf("R3 count v%0d", v), 32'(phy_count), 32'(e_cnt));
        check(phy_table == e_tbl, $sformatf("R3 table v%0d", v), 32'(phy_table), 32'(e_tbl));
        check(int'(primary_phy) == V_PRIM[v], $sformatf("R7 primary v%0d", v),
              32'(primary_phy), 32'(V_PRIM[v]));
        check(preamble_req == V_PRE[v] && preamble_req == e_pre,
              $sformatf("R6 preamble_req v%0d", v), 32'(preamble_req), 32'(e_pre));
        check(no_phy_err == V_ERR[v], $sformatf("R8 no_phy_err v%0d", v),
              32'(no_phy_err), 32'(V_ERR[v]));
        check(adv_value == e_adv, $sformatf("R4 adv_value v%0d", v), 32'(adv_value), 32'(e_adv));
        check(n_req - r0 == e_req, $sformatf("R1 request count v%0d", v), 32'(n_req - r0), 32'(e_req));
        check(order_err == o0, $sformatf("R1 R2 R4 request order v%0d", v), 32'(order_err - o0), 0);
        check(pre_err == p0, $sformatf("R5 preamble request v%0d", v), 32'(pre_err - p0), 0);
        check(overlap_err == x0, $sformatf("R9 one outstanding v%0d", v), 32'(overlap_err - x0), 0);
        if (start_in_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, $sformatf("R10 done one cycle v%0d", v), 32'(done), 0);
    endtask

    initial begin
        bit          keep_pre, keep_err;
        logic [15:0] keep_adv;
        logic [4:0]  keep_prim;
        logic [CNT_W-1:0] keep_cnt;
        int          r0;

        repeat (3) @(negedge clk);
        // R11 / R7 / R8: reset state
        check(phy_count == '0, "R11 reset count", 32'(phy_count), 0);
        check(primary_phy == 5'd1, "R7 reset primary", 32'(primary_phy), 1);
        check(!no_phy_err, "R8 reset no_phy_err", 32'(no_phy_err), 0);
        check(adv_value == '0 && !preamble_req && !done && !req_valid,
              "R11 reset outputs", {adv_value, 13'd0, preamble_req, done, req_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            run_vec(v, 0, 0);
            repeat (3) @(negedge clk);
        end

        // R10: start during a sweep is ignored
        run_vec(2, 25, 0);

        // R10: start in the done cycle of a sweep ending on full table at address 31
        run_vec(5, 0, 1);
        keep_cnt = phy_count; keep_prim = primary_phy; keep_adv = adv_value;
        keep_pre = preamble_req; keep_err = no_phy_err;
        r0 = n_req;
        repeat (40) @(negedge clk);
        check(n_req == r0, "R10 no request after start in done cycle", 32'(n_req - r0), 0);
        check(phy_count == keep_cnt && primary_phy == keep_prim && adv_value == keep_adv &&
              preamble_req == keep_pre && no_phy_err == keep_err,
              "R10 results held", 32'(adv_value), 32'(keep_adv));

        // R8: error clears at the start of a successful sweep after a failed one
        run_vec(0, 0, 0);
        @(negedge clk); start = 1'b1;
        cur_mask = V_MASK[1]; cur_supp = V_SUPP[1];
        @(negedge clk); start = 1'b0;
        check(!no_phy_err && adv_value == '0, "R8 R4 cleared at start",
              {15'd0, no_phy_err, adv_value}, 0);
        begin
            bit seen;
            wait_done(seen);
        end
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule